// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block holds the program counter of a 32-bit processor whose instructions are one aligned word each, and it works out the address of the next instruction. On every rising clock edge the counter takes one of three values: the address one word ahead, a target relative to that address for a conditional branch, or a target for an unconditional jump built from a 26-bit word index.

The decode and execute logic drives it. They supply the current instruction's 16-bit displacement and its 26-bit jump index, a branch request, the zero flag from the ALU comparison, and a jump request. The unit returns the current address for instruction fetch, and the address one word ahead for any logic that needs the return point or the branch base.

Top module: `pc_seq_unit`

## Requirements
- R1: When `rst` is high at a rising edge, the counter loads 0, whatever the control inputs are.
- R2: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32.
- R3: With no jump and no taken branch, the counter advances to `pc_o` + 4 at the next edge, and it wraps from 0xFFFFFFFC to 0.
- R4: A branch is taken when `branch_en` and `alu_zero` are both 1. The new counter value is `pc_o` + 4 + (the sign-extended `disp_i` multiplied by 4). Bit 15 of `disp_i` is the sign, so negative displacements go backwards.
- R5: When `branch_en` is 1 and `alu_zero` is 0, or when `alu_zero` is 1 and `branch_en` is 0, the counter takes the sequential value.
- R6: With `jump_en` high, the new counter value is {(`pc_o`+4)[31:28], `jidx_i`[25:0], 2'b00}.
- R7: Priority is jump first, then a taken branch, then the sequential step.
- R8: The upper four bits of a jump target come from `pc_o`+4. A jump issued from 0x0FFFFFFC therefore lands in the region whose top bits are 0x1.
- R9: After reset, bits [1:0] of `pc_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| disp_i | input | 16 | Signed branch displacement, counted in words |
| jidx_i | input | 26 | Jump word index |
| branch_en | input | 1 | Branch request for the current instruction |
| alu_zero | input | 1 | ALU zero flag from the branch comparison |
| jump_en | input | 1 | Jump request for the current instruction |
| pc_o | output | 32 | Current instruction address |
| pc_plus4_o | output | 32 | Current address plus 4 |

## Verification
The bound checker tests on every cycle that:
- reset forces zero;
- each selection rule yields the value its inputs call for one edge later, including that a jump overrides a taken branch;
- the address stays word aligned.

Only the bench's scenarios can show the corner values. These are the wrap of the sequential step past the top of the address space, a negative displacement that crosses below zero, and a jump from the last word of a 256 MB region landing in the next region. Reset asserted together with a jump request, and a zero flag without a branch request, are also covered only by the bench.

// File: rtl/pc_seq_unit.sv
module pc_seq_unit #(
  parameter int          AW       = 32,
  parameter int          DW       = 16,
  parameter int          JW       = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] disp_i,
  input  logic [JW-1:0] jidx_i,
  input  logic          branch_en,
  input  logic          alu_zero,
  input  logic          jump_en,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] pc_plus4_o
);
  localparam int RW = AW - JW - 2;

  logic [AW-1:0] pc_q, pc_d, br_off, br_tgt, j_tgt;
  logic          take_br;

  assign pc_plus4_o = pc_q + AW'(4);
  assign br_off     = {{(AW-DW-2){disp_i[DW-1]}}, disp_i, 2'b00};
  assign br_tgt     = pc_plus4_o + br_off;
  assign j_tgt      = {pc_plus4_o[AW-1 -: RW], jidx_i, 2'b00};
  assign take_br    = branch_en & alu_zero;

  always_comb begin
    if (jump_en)      pc_d = j_tgt;
    else if (take_br) pc_d = br_tgt;
    else              pc_d = pc_plus4_o;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC[AW-1:0];
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] disp_i,
  input logic [25:0] jidx_i,
  input logic        branch_en,
  input logic        alu_zero,
  input logic        jump_en,
  input logic [31:0] pc_o,
  input logic [31:0] pc_plus4_o
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc_o == 32'h0);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && !(branch_en && alu_zero)) |=> pc_o == $past(pc_o) + 32'd4);

  p_branch_tgt_r4: assert property (@(posedge clk) disable iff (rst)
    (!jump_en && branch_en && alu_zero) |=>
      pc_o == $past(pc_o) + 32'd4 + {{14{$past(disp_i[15])}}, $past(disp_i), 2'b00});

  p_jump_tgt_r7: assert property (@(posedge clk) disable iff (rst)
    jump_en |=> pc_o == {$past(pc_plus4_o[31:28]), $past(jidx_i), 2'b00});

  p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

bind pc_seq_unit pc_seq_unit_chk u_chk (
  .clk(clk), .rst(rst), .disp_i(disp_i), .jidx_i(jidx_i),
  .branch_en(branch_en), .alu_zero(alu_zero), .jump_en(jump_en),
  .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
);

// File: tb/pc_seq_unit_tb.sv
module pc_seq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] disp_i = '0;
  logic [25:0] jidx_i = '0;
  logic        branch_en = 0, alu_zero = 0, jump_en = 0;
  logic [31:0] pc_o, pc_plus4_o;

  int errors = 0, checks = 0;
  logic [31:0] model_pc = 32'h0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_seq_unit u_dut (
    .clk(clk), .rst(rst), .disp_i(disp_i), .jidx_i(jidx_i),
    .branch_en(branch_en), .alu_zero(alu_zero), .jump_en(jump_en),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc_o, e);
      check({t, " R2 plus4"}, pc_plus4_o, e + 32'd4);
      check({t, " R9 align"}, {30'd0, pc_o[1:0]}, 32'd0);
    end
  end

  task automatic step(input logic [15:0] d, input logic [25:0] j, input logic br,
                      input logic z, input logic jp, input string tag);
    logic [31:0] p4;
    @(negedge clk);
    rst = 0; disp_i = d; jidx_i = j; branch_en = br; alu_zero = z; jump_en = jp;
    p4 = model_pc + 32'd4;
    if (jp)           model_pc = {p4[31:28], j, 2'b00};
    else if (br && z) model_pc = p4 + {{14{d[15]}}, d, 2'b00};
    else              model_pc = p4;
    exp_q.push_back(model_pc);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1; jump_en = 1; jidx_i = 26'h155; branch_en = 1; alu_zero = 1;
    model_pc = 32'h0;
    exp_q.push_back(model_pc);
    tag_q.push_back(tag);
  endtask

  initial begin
    exp_q.push_back(32'h0);
    tag_q.push_back("R1 reset");
    step(16'h0, 26'h0, 0, 0, 0, "R3 seq");
    step(16'h0, 26'h0, 0, 0, 0, "R3 seq");
    step(16'h0003, 26'h0, 1, 1, 0, "R4 fwd branch");
    step(16'h0005, 26'h0, 1, 0, 0, "R5 branch not taken");
    step(16'h0005, 26'h0, 0, 1, 0, "R5 zero without branch");
    step(16'hFFFC, 26'h0, 1, 1, 0, "R4 back branch");
    step(16'h0040, 26'h0ABCDE, 1, 1, 1, "R7 jump over branch");
    step(16'h0, 26'h0000100, 0, 0, 1, "R6 jump");
    step(16'h0, 26'h3FFFFFF, 0, 0, 1, "R6 jump to region end");
    step(16'h0, 26'h0000010, 0, 0, 1, "R8 jump crosses region");
    do_reset("R1 reset with jump");
    step(16'hFFFE, 26'h0, 1, 1, 0, "R4 neg below zero");
    step(16'h0, 26'h0, 0, 0, 0, "R3 wrap");
    step(16'h0, 26'h0, 0, 0, 0, "R3 after wrap");
    @(negedge clk);
    jump_en = 0; branch_en = 0;
    repeat (2) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule